// File: doc/BRIEF.md
# Same-Sign Single-Precision Float Adder

This block adds two 32-bit binary floating-point words with 1 sign bit, 8 exponent bits (bias 127) and 23 fraction bits, meant for operands that share a sign. Each operand is decoded first. The hidden one is restored to form a 24-bit mantissa. The operand with the smaller exponent is right-shifted by the exponent gap, and three extra bits (guard, round and sticky) keep what is shifted out. The two mantissas are then summed. On a carry into the 2.x range the sum is shifted right once and the exponent is incremented. The result is rounded to nearest, ties to even, and packed back into a word.

Special operands bypass the arithmetic path. NaN, infinity and zero are recognised from the exponent and fraction patterns and produce fixed results. An operand whose exponent field is zero is treated as zero.

A caller presents `a_i`, `b_i` and a one-cycle strobe `in_valid_i`. The packed sum appears on `y_o` one clock later, marked by `out_valid_o`. Between strobes, `y_o` keeps the last result.

Top module: `fp_same_sign_adder`

## Requirements
- R1: `out_valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was sampled high, and is low otherwise. After reset deasserts, `out_valid_o` is 0 and `y_o` is 0.
- R2: `y_o` changes only on a clock edge where `in_valid_i` is high. Otherwise it holds its value, whatever `a_i` and `b_i` do.
- R3: For finite non-zero operands, the exponents are compared and the smaller one's mantissa is right-shifted by the gap before the add. The result magnitude (bits 30:0) is never below either operand's magnitude. Example: 0x3FC00000 + 0x40500000 = 0x40980000, in either operand order.
- R4: When the mantissa sum reaches 2.0 or more, it is shifted right by one and the exponent is incremented. Examples: 0x3F800000 + 0x3F800000 = 0x40000000, and 0x40400000 + 0x40A00000 = 0x41000000.
- R5: Rounding is to nearest, with ties going to the even fraction.
  - 0x3F800000 + 0x33800000 = 0x3F800000.
  - 0x3F800001 + 0x33800000 = 0x3F800002.
  - 0x3F800000 + 0x33800001 = 0x3F800001.
  - A round-up that overflows the mantissa bumps the exponent: 0x3F7FFFFF + 0x33000000 = 0x3F800000.
- R6: When the exponent fields differ by 25 or more, the result is the operand with the larger exponent, bit for bit. Examples: 0x3F800000 + 0x33000000 = 0x3F800000, and 0x32800000 + 0x3F800001 = 0x3F800001.
- R7: If the exponent after normalisation and rounding reaches 255, the result is infinity with the result sign (0x7F800000 or 0xFF800000). Examples: 0x7F7FFFFF + 0x7F7FFFFF = 0x7F800000, and 0x7F7FFFFF + 0x73000000 = 0x7F800000 through a rounding carry.
- R8: If either operand has exponent 255 and a non-zero fraction (NaN), the result is 0x7FC00000, even when the other operand is infinity.
- R9: If neither operand is NaN and one has exponent 255 with a zero fraction (infinity), the result is that infinity word, sign included.
- R10: An operand with exponent field 0 counts as zero. If `a_i` is zero, the result is `b_i`. Otherwise, if `b_i` is zero, the result is `a_i`.
- R11: On the arithmetic path, the result sign bit (bit 31) is the sign bit of `a_i`. Example: 0xBFC00000 + 0xC0500000 = 0xC0980000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are present this cycle |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| out_valid_o | output | 1 | `y_o` holds a new result |
| y_o | output | 32 | Packed sum |

## Verification
Two functions can land on the same add: a rounding carry out of the 24-bit mantissa, and the exponent overflow to infinity that this carry can cause. The bench provokes both at once with 0x7F7FFFFF + 0x73000000. The 24-step gap leaves an exact half-ulp tie, and the largest finite fraction, being odd, rounds up. The result must be exactly 0x7F800000, not a wrapped exponent or a truncated 0x7F7FFFFF. The related case with no overflow, 0x3F7FFFFF + 0x33000000, must land on 0x3F800000, which shows that the carry from rounding re-enters the exponent.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int EXT_W   = MANT_W + 2;      // mantissa + guard + round
  localparam int SUM_W   = EXT_W + 1;
  localparam int FAR_LIM = MANT_W + 1;      // gap at which small operand vanishes
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;

  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } fp_cls_t;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpa_classify.sv
module fpa_classify
  import fpa_pkg::*;
(
  input  fp_t               op_i,
  output fp_cls_t           cls_o,
  output logic [MANT_W-1:0] mant_o
);
  logic exp_ones, exp_zero, frac_zero;

  assign exp_ones  = &op_i.exp;
  assign exp_zero  = ~|op_i.exp;
  assign frac_zero = ~|op_i.frac;

  assign cls_o.is_zero = exp_zero;            // subnormals flushed
  assign cls_o.is_inf  = exp_ones & frac_zero;
  assign cls_o.is_nan  = exp_ones & ~frac_zero;
  assign mant_o        = {~exp_zero, op_i.frac};
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  fp_t               a_i,
  input  fp_t               b_i,
  input  logic [MANT_W-1:0] ma_i,
  input  logic [MANT_W-1:0] mb_i,
  output fp_t               big_o,
  output logic [EXT_W-1:0]  big_ext_o,
  output logic [EXT_W-1:0]  small_ext_o,
  output logic              sticky_o,
  output logic              far_o
);
  localparam int WIDE_W = MANT_W + FAR_LIM;

  logic              a_big;
  logic [EXP_W-1:0]  gap;
  logic [MANT_W-1:0] m_small;
  logic [WIDE_W-1:0] wide;

  assign a_big   = a_i.exp >= b_i.exp;
  assign big_o   = a_big ? a_i : b_i;
  assign gap     = a_big ? (a_i.exp - b_i.exp) : (b_i.exp - a_i.exp);
  assign m_small = a_big ? mb_i : ma_i;
  assign far_o   = gap >= EXP_W'(FAR_LIM);

  assign big_ext_o   = {(a_big ? ma_i : mb_i), 2'b00};
  assign wide        = {m_small, {FAR_LIM{1'b0}}} >> gap;
  assign small_ext_o = wide[WIDE_W-1 -: EXT_W];
  assign sticky_o    = |wide[WIDE_W-EXT_W-1:0];
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round
  import fpa_pkg::*;
(
  input  logic              sgn_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [EXT_W-1:0]  big_ext_i,
  input  logic [EXT_W-1:0]  small_ext_i,
  input  logic              sticky_i,
  output logic [WORD_W-1:0] word_o
);
  logic [SUM_W-1:0]  sum;
  logic              carry, g_bit, r_bit, s_bit, rnd_up, ovf;
  logic [MANT_W-1:0] mant;
  logic [MANT_W:0]   rnd;
  logic [EXP_W:0]    exp_n, exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sum   = {1'b0, big_ext_i} + {1'b0, small_ext_i};
  assign carry = sum[SUM_W-1];

  always_comb begin
    if (carry) begin
      mant  = sum[SUM_W-1 -: MANT_W];
      g_bit = sum[2];
      r_bit = sum[1];
      s_bit = sum[0] | sticky_i;
    end else begin
      mant  = sum[SUM_W-2 -: MANT_W];
      g_bit = sum[1];
      r_bit = sum[0];
      s_bit = sticky_i;
    end
    // R4
    if (big_ext_i[EXT_W-1]) norm_lead_chk: assert (mant[MANT_W-1]);
  end

  assign exp_n  = {1'b0, exp_i} + (EXP_W+1)'(carry);
  assign rnd_up = g_bit & (r_bit | s_bit | mant[0]);
  assign rnd    = {1'b0, mant} + (MANT_W+1)'(rnd_up);
  assign exp_f  = exp_n + (EXP_W+1)'(rnd[MANT_W]);
  assign frac_f = rnd[MANT_W] ? rnd[MANT_W-1:1] : rnd[FRAC_W-1:0];
  assign ovf    = exp_f >= (EXP_W+1)'(EXP_MAX);

  assign word_o = ovf ? {sgn_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                      : {sgn_i, exp_f[EXP_W-1:0], frac_f};
endmodule

// File: rtl/fp_same_sign_adder.sv
module fp_same_sign_adder
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] y_o
);
  fp_t               a_w, b_w, big;
  fp_cls_t           cls_a, cls_b;
  logic [MANT_W-1:0] ma, mb;
  logic [EXT_W-1:0]  big_ext, small_ext;
  logic              sticky, far;
  logic [WORD_W-1:0] sum_word, res;

  assign a_w = a_i;
  assign b_w = b_i;

  fpa_classify u_cls_a (.op_i(a_w), .cls_o(cls_a), .mant_o(ma));
  fpa_classify u_cls_b (.op_i(b_w), .cls_o(cls_b), .mant_o(mb));

  fpa_align u_align (
    .a_i(a_w), .b_i(b_w), .ma_i(ma), .mb_i(mb),
    .big_o(big), .big_ext_o(big_ext), .small_ext_o(small_ext),
    .sticky_o(sticky), .far_o(far)
  );

  fpa_norm_round u_nr (
    .sgn_i(a_w.sgn), .exp_i(big.exp), .big_ext_i(big_ext),
    .small_ext_i(small_ext), .sticky_i(sticky), .word_o(sum_word)
  );

  always_comb begin
    if (cls_a.is_nan || cls_b.is_nan) res = QNAN_WORD;
    else if (cls_a.is_inf)            res = a_i;
    else if (cls_b.is_inf)            res = b_i;
    else if (cls_a.is_zero)           res = b_i;
    else if (cls_b.is_zero)           res = a_i;
    else if (far)                     res = big;
    else                              res = sum_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) y_o <= res;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R2
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(y_o));
  // R8
  qnan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (cls_a.is_nan || cls_b.is_nan) |=> y_o == QNAN_WORD);
  // R3
  mag_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !cls_a.is_nan && !cls_b.is_nan && !cls_a.is_inf && !cls_b.is_inf
      && !cls_a.is_zero && !cls_b.is_zero
    |=> (y_o[WORD_W-2:0] >= $past(a_i[WORD_W-2:0])) && (y_o[WORD_W-2:0] >= $past(b_i[WORD_W-2:0])));
endmodule

// File: tb/fp_same_sign_adder_tb.sv
`timescale 1ns/1ps
module fp_same_sign_adder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        out_valid_o;
  logic [31:0] y_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fp_same_sign_adder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .y_o(y_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic add_chk(input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    a_i = a; b_i = b; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(out_valid_o === 1'b1, {req, " valid"}, {31'd0, out_valid_o}, 32'd1);
    check(y_o === exp, req, y_o, exp);
  endtask

  task automatic t_reset;
    check(out_valid_o === 1'b0, "R1 reset valid", {31'd0, out_valid_o}, 32'd0);
    check(y_o === 32'd0, "R1 reset y", y_o, 32'd0);
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    add_chk(32'h40000000, 32'h40000000, 32'h40800000, "R2 prep");
    kept = y_o;
    a_i = 32'h7F800001; b_i = 32'h12345678;   // valid low: must be ignored
    @(negedge clk_i);
    check(out_valid_o === 1'b0, "R1 idle valid", {31'd0, out_valid_o}, 32'd0);
    check(y_o === kept, "R2 hold", y_o, kept);
    @(negedge clk_i);
    check(y_o === kept, "R2 hold second", y_o, kept);
  endtask

  task automatic t_basic;
    add_chk(32'h3FC00000, 32'h40500000, 32'h40980000, "R3 align");
    add_chk(32'h40500000, 32'h3FC00000, 32'h40980000, "R3 swapped");
  endtask

  task automatic t_carry;
    add_chk(32'h3F800000, 32'h3F800000, 32'h40000000, "R4 one+one");
    add_chk(32'h40400000, 32'h40A00000, 32'h41000000, "R4 three+five");
  endtask

  task automatic t_round;
    add_chk(32'h3F800000, 32'h33800000, 32'h3F800000, "R5 tie even down");
    add_chk(32'h3F800001, 32'h33800000, 32'h3F800002, "R5 tie odd up");
    add_chk(32'h3F800000, 32'h33800001, 32'h3F800001, "R5 above half");
    add_chk(32'h3F7FFFFF, 32'h33000000, 32'h3F800000, "R5 round carry");
  endtask

  task automatic t_far;
    add_chk(32'h3F800000, 32'h33000000, 32'h3F800000, "R6 gap 25");
    add_chk(32'h32800000, 32'h3F800001, 32'h3F800001, "R6 b larger");
  endtask

  task automatic t_ovf;
    add_chk(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R7 pos ovf");
    add_chk(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, "R7 neg ovf");
    add_chk(32'h7F7FFFFF, 32'h73000000, 32'h7F800000, "R7 round ovf");
  endtask

  task automatic t_nan;
    add_chk(32'h7F800001, 32'h3F800000, 32'h7FC00000, "R8 nan a");
    add_chk(32'h7F800000, 32'hFFC00000, 32'h7FC00000, "R8 nan b with inf");
  endtask

  task automatic t_inf;
    add_chk(32'h7F800000, 32'h3F800000, 32'h7F800000, "R9 inf a");
    add_chk(32'hC0000000, 32'hFF800000, 32'hFF800000, "R9 neg inf b");
  endtask

  task automatic t_zero;
    add_chk(32'h00000000, 32'h40490FDB, 32'h40490FDB, "R10 a zero");
    add_chk(32'hC0000000, 32'h80000000, 32'hC0000000, "R10 b zero");
    add_chk(32'h00000001, 32'h3F800000, 32'h3F800000, "R10 subnormal");
  endtask

  task automatic t_sign;
    add_chk(32'hBFC00000, 32'hC0500000, 32'hC0980000, "R11 negative");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_carry();
    t_round();
    t_far();
    t_ovf();
    t_nan();
    t_inf();
    t_zero();
    t_sign();
    t_hold();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule